// File: doc/BRIEF.md
# Four-Port Speed-Segregated MII Bus Router

This block sits between four PHY channel data paths and a repeater. It offers the repeater two shared buses. Fast ports, which run at 100 Mbit/s, share a nibble-wide bus that carries the receive nibble, data-valid, receive-error, the transmit nibble and transmit-error. Slow ports, which run at 10 Mbit/s, share a one-bit serial bus. Each port goes to the bus that matches its resolved speed. The speed is a per-port input, and nothing else configures the routing.

The repeater picks the port that drives each shared receive bus, and the ports that take data from each shared transmit bus, through per-port enables. There are two submodes. In the separate submode, each port has distinct enable, carrier and collision lines for the slow bus and for the fast bus. In the smart submode, each port has one common enable, carrier and collision set that serves whatever speed the port runs at. Every output is registered. An output shows the effect of the inputs sampled at the previous rising clock edge.

Top module: `mii_speed_router`

## Requirements
- R1: While reset is held and in the first cycle after it, every output is zero.
- R2: When exactly one fast port has its receive enable asserted, the fast bus carries that port's receive nibble, data-valid and receive-error one cycle later, and the fast contention flag is low.
- R3: When exactly one slow port has its receive enable asserted, the slow bus carries bit 0 of that port's receive nibble one cycle later, and the slow contention flag is low.
- R4: A receive or transmit enable for the bus that does not match the port's speed has no effect. That port neither drives nor takes data from either bus.
- R5: If no port is enabled onto a receive bus, that bus outputs all zeros, with data-valid and receive-error low.
- R6: If two or more ports are enabled onto the same receive bus, the port with the lowest index drives it and that bus's contention flag is high.
- R7: A port enabled onto the transmit bus that matches its speed gets tx_en high. A fast port also gets the fast transmit nibble and transmit-error. A slow port gets the serial bit on nibble bit 0, with the upper bits and tx_er zero. A port that is not enabled gets nibble, tx_en and tx_er all zero.
- R8: In the separate submode (smart_sel=0), a port's carrier and collision appear only on the line for its own speed, the other-speed line is zero, and the common lines are zero.
- R9: In the smart submode (smart_sel=1), the common carrier and collision lines follow the port's carrier and collision at either speed. The separate status lines are zero and the separate enables are ignored.
- R10: In the separate submode, the common enables are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smart_sel | input | 1 | 1 = smart submode, 0 = separate submode |
| port_fast | input | NPORT | Per-port resolved speed, 1 = 100 Mbit/s |
| phy_rxd | input | NPORT*NIB | Per-port receive nibble (slow ports use bit 0) |
| phy_rx_dv | input | NPORT | Per-port receive data-valid |
| phy_rx_er | input | NPORT | Per-port receive error |
| phy_crs | input | NPORT | Per-port carrier sense |
| phy_col | input | NPORT | Per-port collision |
| phy_txd | output | NPORT*NIB | Per-port transmit nibble |
| phy_tx_en | output | NPORT | Per-port transmit enable |
| phy_tx_er | output | NPORT | Per-port transmit error |
| sep_rx_en10 | input | NPORT | Separate submode slow receive enable |
| sep_rx_en100 | input | NPORT | Separate submode fast receive enable |
| sep_tx_en10 | input | NPORT | Separate submode slow transmit enable |
| sep_tx_en100 | input | NPORT | Separate submode fast transmit enable |
| cmn_rx_en | input | NPORT | Smart submode common receive enable |
| cmn_tx_en | input | NPORT | Smart submode common transmit enable |
| sep_crs10 | output | NPORT | Separate submode slow carrier |
| sep_crs100 | output | NPORT | Separate submode fast carrier |
| sep_col10 | output | NPORT | Separate submode slow collision |
| sep_col100 | output | NPORT | Separate submode fast collision |
| cmn_crs | output | NPORT | Smart submode common carrier |
| cmn_col | output | NPORT | Smart submode common collision |
| fast_rxd | output | NIB | Shared fast receive nibble |
| fast_rx_dv | output | 1 | Shared fast data-valid |
| fast_rx_er | output | 1 | Shared fast receive error |
| fast_txd | input | NIB | Shared fast transmit nibble |
| fast_tx_er | input | 1 | Shared fast transmit error |
| slow_rxd | output | 1 | Shared serial receive bit |
| slow_txd | input | 1 | Shared serial transmit bit |
| fast_contend | output | 1 | More than one port enabled onto the fast receive bus |
| slow_contend | output | 1 | More than one port enabled onto the slow receive bus |

## Verification
The routing is driven by random mixes of port speeds, submode, enables and data. Because some ports are fast and some slow in the same cycle, a port that leaks onto the wrong bus shows up at once. Directed cases cover the following:
- No port enabled, which separates an idle bus from a stale one.
- Several ports enabled on one bus, which tests that the lowest index wins and that the contention flag rises.
- Enables asserted only for the wrong speed.
- Each submode with the other submode's enables toggled, which shows whether the right control set is in use.

// File: rtl/mii_route_pkg.sv
`timescale 1ns/1ps
package mii_route_pkg;

  typedef enum logic {SUB_SEPARATE = 1'b0, SUB_SMART = 1'b1} submode_e;

  // Lowest set bit of a request vector as a one-hot word.
  function automatic logic [31:0] lowest_onehot(input logic [31:0] req);
    return req & (~req + 32'd1);
  endfunction

  // True when two or more request bits are set.
  function automatic logic many_set(input logic [31:0] req);
    return (req & (req - 32'd1)) != 32'd0;
  endfunction

  // Picks which enable a port obeys for one bus speed.
  function automatic logic pick_enable(input submode_e mode, input logic cmn, input logic sep);
    return (mode == SUB_SMART) ? cmn : sep;
  endfunction

endpackage

// File: rtl/mii_bus_arbiter.sv
`timescale 1ns/1ps
module mii_bus_arbiter
  import mii_route_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int W     = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPORT-1:0]   req,
  input  logic [NPORT*W-1:0] data,
  output logic [W-1:0]       bus_q,
  output logic               contend_q
);

  logic [31:0]      grant_w;
  logic [NPORT-1:0] grant;
  logic [W-1:0]     bus_nxt;
  logic             multi;

  always_comb begin
    grant_w = lowest_onehot(32'(req));
    grant   = grant_w[NPORT-1:0];
    multi   = many_set(32'(req));
    bus_nxt = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (grant[i]) bus_nxt = bus_nxt | data[i*W +: W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q     <= '0;
      contend_q <= 1'b0;
    end else begin
      bus_q     <= bus_nxt;
      contend_q <= multi;
    end
  end

  // R5
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (bus_q == '0 && !contend_q));

  // R6
  contention_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(req) > 1) |=> contend_q);

  // R6
  lowest_port_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |=> (bus_q == $past(data[W-1:0])));

  // R2
  single_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(req) == 1) |=> !contend_q);

endmodule

// File: rtl/mii_port_gate.sv
`timescale 1ns/1ps
module mii_port_gate
  import mii_route_pkg::*;
#(
  parameter int NIB = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  submode_e       mode,
  input  logic           is_fast,
  input  logic           sep_rx_en10,
  input  logic           sep_rx_en100,
  input  logic           sep_tx_en10,
  input  logic           sep_tx_en100,
  input  logic           cmn_rx_en,
  input  logic           cmn_tx_en,
  input  logic           crs_in,
  input  logic           col_in,
  input  logic [NIB-1:0] fast_txd,
  input  logic           fast_tx_er,
  input  logic           slow_txd,
  output logic           rx_sel_fast,
  output logic           rx_sel_slow,
  output logic [NIB-1:0] txd_q,
  output logic           tx_en_q,
  output logic           tx_er_q,
  output logic           crs10_q,
  output logic           crs100_q,
  output logic           col10_q,
  output logic           col100_q,
  output logic           cmn_crs_q,
  output logic           cmn_col_q
);

  logic           tx_sel_fast, tx_sel_slow;
  logic [NIB-1:0] txd_nxt;
  logic           tx_en_nxt, tx_er_nxt;
  logic           smart;

  assign smart       = (mode == SUB_SMART);
  assign rx_sel_fast =  is_fast & pick_enable(mode, cmn_rx_en, sep_rx_en100);
  assign rx_sel_slow = ~is_fast & pick_enable(mode, cmn_rx_en, sep_rx_en10);
  assign tx_sel_fast =  is_fast & pick_enable(mode, cmn_tx_en, sep_tx_en100);
  assign tx_sel_slow = ~is_fast & pick_enable(mode, cmn_tx_en, sep_tx_en10);

  always_comb begin
    txd_nxt   = '0;
    tx_en_nxt = 1'b0;
    tx_er_nxt = 1'b0;
    if (tx_sel_fast) begin
      txd_nxt   = fast_txd;
      tx_en_nxt = 1'b1;
      tx_er_nxt = fast_tx_er;
    end else if (tx_sel_slow) begin
      txd_nxt   = NIB'(slow_txd);
      tx_en_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q     <= '0;
      tx_en_q   <= 1'b0;
      tx_er_q   <= 1'b0;
      crs10_q   <= 1'b0;
      crs100_q  <= 1'b0;
      col10_q   <= 1'b0;
      col100_q  <= 1'b0;
      cmn_crs_q <= 1'b0;
      cmn_col_q <= 1'b0;
    end else begin
      txd_q     <= txd_nxt;
      tx_en_q   <= tx_en_nxt;
      tx_er_q   <= tx_er_nxt;
      crs10_q   <= !smart & !is_fast & crs_in;
      crs100_q  <= !smart &  is_fast & crs_in;
      col10_q   <= !smart & !is_fast & col_in;
      col100_q  <= !smart &  is_fast & col_in;
      cmn_crs_q <=  smart & crs_in;
      cmn_col_q <=  smart & col_in;
    end
  end

  // R7
  idle_tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_sel_fast && !tx_sel_slow) |=> (!tx_en_q && !tx_er_q && txd_q == '0));

  // R8
  slow_port_fast_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_fast |=> (!crs100_q && !col100_q));

  // R9
  smart_sep_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smart |=> (!crs10_q && !crs100_q && !col10_q && !col100_q));

  // R8
  sep_common_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smart |=> (!cmn_crs_q && !cmn_col_q));

  // R4
  one_bus_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_sel_fast && rx_sel_slow));

endmodule

// File: rtl/mii_speed_router.sv
`timescale 1ns/1ps
module mii_speed_router
  import mii_route_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int NIB   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smart_sel,
  input  logic [NPORT-1:0]     port_fast,
  input  logic [NPORT*NIB-1:0] phy_rxd,
  input  logic [NPORT-1:0]     phy_rx_dv,
  input  logic [NPORT-1:0]     phy_rx_er,
  input  logic [NPORT-1:0]     phy_crs,
  input  logic [NPORT-1:0]     phy_col,
  output logic [NPORT*NIB-1:0] phy_txd,
  output logic [NPORT-1:0]     phy_tx_en,
  output logic [NPORT-1:0]     phy_tx_er,
  input  logic [NPORT-1:0]     sep_rx_en10,
  input  logic [NPORT-1:0]     sep_rx_en100,
  input  logic [NPORT-1:0]     sep_tx_en10,
  input  logic [NPORT-1:0]     sep_tx_en100,
  input  logic [NPORT-1:0]     cmn_rx_en,
  input  logic [NPORT-1:0]     cmn_tx_en,
  output logic [NPORT-1:0]     sep_crs10,
  output logic [NPORT-1:0]     sep_crs100,
  output logic [NPORT-1:0]     sep_col10,
  output logic [NPORT-1:0]     sep_col100,
  output logic [NPORT-1:0]     cmn_crs,
  output logic [NPORT-1:0]     cmn_col,
  output logic [NIB-1:0]       fast_rxd,
  output logic                 fast_rx_dv,
  output logic                 fast_rx_er,
  input  logic [NIB-1:0]       fast_txd,
  input  logic                 fast_tx_er,
  output logic                 slow_rxd,
  input  logic                 slow_txd,
  output logic                 fast_contend,
  output logic                 slow_contend
);

  localparam int FAST_W = NIB + 2;

  submode_e                mode;
  logic [NPORT-1:0]        req_fast, req_slow;
  logic [NPORT*FAST_W-1:0] fast_data;
  logic [NPORT-1:0]        slow_data;
  logic [FAST_W-1:0]       fast_bus;

  assign mode = smart_sel ? SUB_SMART : SUB_SEPARATE;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign fast_data[p*FAST_W +: FAST_W] = {phy_rxd[p*NIB +: NIB], phy_rx_dv[p], phy_rx_er[p]};
    assign slow_data[p] = phy_rxd[p*NIB];

    mii_port_gate #(.NIB(NIB)) u_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode         (mode),
      .is_fast      (port_fast[p]),
      .sep_rx_en10  (sep_rx_en10[p]),
      .sep_rx_en100 (sep_rx_en100[p]),
      .sep_tx_en10  (sep_tx_en10[p]),
      .sep_tx_en100 (sep_tx_en100[p]),
      .cmn_rx_en    (cmn_rx_en[p]),
      .cmn_tx_en    (cmn_tx_en[p]),
      .crs_in       (phy_crs[p]),
      .col_in       (phy_col[p]),
      .fast_txd     (fast_txd),
      .fast_tx_er   (fast_tx_er),
      .slow_txd     (slow_txd),
      .rx_sel_fast  (req_fast[p]),
      .rx_sel_slow  (req_slow[p]),
      .txd_q        (phy_txd[p*NIB +: NIB]),
      .tx_en_q      (phy_tx_en[p]),
      .tx_er_q      (phy_tx_er[p]),
      .crs10_q      (sep_crs10[p]),
      .crs100_q     (sep_crs100[p]),
      .col10_q      (sep_col10[p]),
      .col100_q     (sep_col100[p]),
      .cmn_crs_q    (cmn_crs[p]),
      .cmn_col_q    (cmn_col[p])
    );
  end

  mii_bus_arbiter #(.NPORT(NPORT), .W(FAST_W)) u_fast_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req_fast),
    .data      (fast_data),
    .bus_q     (fast_bus),
    .contend_q (fast_contend)
  );

  mii_bus_arbiter #(.NPORT(NPORT), .W(1)) u_slow_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req_slow),
    .data      (slow_data),
    .bus_q     (slow_rxd),
    .contend_q (slow_contend)
  );

  assign fast_rxd   = fast_bus[FAST_W-1:2];
  assign fast_rx_dv = fast_bus[1];
  assign fast_rx_er = fast_bus[0];

  // R4
  slow_port_off_fast_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_fast == '0) |=> (fast_rxd == '0 && !fast_rx_dv && !fast_rx_er));

endmodule

// File: tb/test_mii_speed_router.sv
`timescale 1ns/1ps
module test_mii_speed_router;
  localparam int NP = 4;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic smart_sel;
  logic [NP-1:0] port_fast, phy_rx_dv, phy_rx_er, phy_crs, phy_col;
  logic [NP*NB-1:0] phy_rxd, phy_txd;
  logic [NP-1:0] phy_tx_en, phy_tx_er;
  logic [NP-1:0] sep_rx_en10, sep_rx_en100, sep_tx_en10, sep_tx_en100, cmn_rx_en, cmn_tx_en;
  logic [NP-1:0] sep_crs10, sep_crs100, sep_col10, sep_col100, cmn_crs, cmn_col;
  logic [NB-1:0] fast_rxd, fast_txd;
  logic fast_rx_dv, fast_rx_er, fast_tx_er, slow_rxd, slow_txd, fast_contend, slow_contend;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  mii_speed_router #(.NPORT(NP), .NIB(NB)) i_mii_speed_router (
    .clk(clk), .rst_n(rst_n), .smart_sel(smart_sel), .port_fast(port_fast),
    .phy_rxd(phy_rxd), .phy_rx_dv(phy_rx_dv), .phy_rx_er(phy_rx_er),
    .phy_crs(phy_crs), .phy_col(phy_col), .phy_txd(phy_txd),
    .phy_tx_en(phy_tx_en), .phy_tx_er(phy_tx_er),
    .sep_rx_en10(sep_rx_en10), .sep_rx_en100(sep_rx_en100),
    .sep_tx_en10(sep_tx_en10), .sep_tx_en100(sep_tx_en100),
    .cmn_rx_en(cmn_rx_en), .cmn_tx_en(cmn_tx_en),
    .sep_crs10(sep_crs10), .sep_crs100(sep_crs100),
    .sep_col10(sep_col10), .sep_col100(sep_col100),
    .cmn_crs(cmn_crs), .cmn_col(cmn_col),
    .fast_rxd(fast_rxd), .fast_rx_dv(fast_rx_dv), .fast_rx_er(fast_rx_er),
    .fast_txd(fast_txd), .fast_tx_er(fast_tx_er),
    .slow_rxd(slow_rxd), .slow_txd(slow_txd),
    .fast_contend(fast_contend), .slow_contend(slow_contend)
  );

  task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    smart_sel = 0; port_fast = '0; phy_rxd = '0; phy_rx_dv = '0; phy_rx_er = '0;
    phy_crs = '0; phy_col = '0; sep_rx_en10 = '0; sep_rx_en100 = '0;
    sep_tx_en10 = '0; sep_tx_en100 = '0; cmn_rx_en = '0; cmn_tx_en = '0;
    fast_txd = '0; fast_tx_er = 0; slow_txd = 0;
  endtask

  // Restates the requirements: later ports overwrite, so lowest index remains.
  task automatic check_all(string ctx);
    logic [NB-1:0] e_rxd = '0;
    logic e_dv = 0, e_er = 0, e_srx = 0;
    int nf = 0, ns = 0;
    logic [NP*NB-1:0] e_txd = '0;
    logic [NP-1:0] e_txen = '0, e_txer = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      logic rx_on, tx_on;
      rx_on = smart_sel ? cmn_rx_en[i] : (port_fast[i] ? sep_rx_en100[i] : sep_rx_en10[i]);
      tx_on = smart_sel ? cmn_tx_en[i] : (port_fast[i] ? sep_tx_en100[i] : sep_tx_en10[i]);
      if (rx_on && port_fast[i]) begin
        nf++; e_rxd = phy_rxd[i*NB +: NB]; e_dv = phy_rx_dv[i]; e_er = phy_rx_er[i];
      end
      if (rx_on && !port_fast[i]) begin
        ns++; e_srx = phy_rxd[i*NB];
      end
      if (tx_on) begin
        e_txen[i] = 1'b1;
        e_txd[i*NB +: NB] = port_fast[i] ? fast_txd : {{(NB-1){1'b0}}, slow_txd};
        e_txer[i] = port_fast[i] & fast_tx_er;
      end
    end
    cmp({ctx, " R2 fast bus"}, {26'd0, fast_rxd, fast_rx_dv, fast_rx_er}, {26'd0, e_rxd, e_dv, e_er});
    cmp({ctx, " R3 slow bus"}, 32'(slow_rxd), 32'(e_srx));
    cmp({ctx, " R6 fast contention"}, 32'(fast_contend), 32'(nf > 1));
    cmp({ctx, " R6 slow contention"}, 32'(slow_contend), 32'(ns > 1));
    cmp({ctx, " R7 tx nibble"}, 32'(phy_txd), 32'(e_txd));
    cmp({ctx, " R7 tx en/er"}, {24'd0, phy_tx_en, phy_tx_er}, {24'd0, e_txen, e_txer});
    cmp({ctx, " R8 sep status"}, {16'd0, sep_crs10, sep_crs100, sep_col10, sep_col100},
        {16'd0, phy_crs & ~port_fast & {NP{!smart_sel}}, phy_crs & port_fast & {NP{!smart_sel}},
         phy_col & ~port_fast & {NP{!smart_sel}}, phy_col & port_fast & {NP{!smart_sel}}});
    cmp({ctx, " R9 common status"}, {24'd0, cmn_crs, cmn_col},
        {24'd0, phy_crs & {NP{smart_sel}}, phy_col & {NP{smart_sel}}});
  endtask

  task automatic step(string ctx);
    @(posedge clk);
    #2;
    check_all(ctx);
  endtask

  task automatic check_zero(string ctx);
    cmp(ctx, {fast_rxd, fast_rx_dv, fast_rx_er, slow_rxd, fast_contend, slow_contend}, '0);
    cmp(ctx, {phy_txd, phy_tx_en, phy_tx_er}, '0);
    cmp(ctx, {sep_crs10, sep_crs100, sep_col10, sep_col100, cmn_crs, cmn_col}, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    clear_inputs();
    // R1: outputs zero under reset even with busy inputs
    port_fast = 4'b1010; phy_crs = '1; phy_col = '1; cmn_rx_en = '1; sep_rx_en100 = '1;
    phy_rxd = 16'hFFFF; phy_rx_dv = '1;
    repeat (3) @(posedge clk);
    #2 check_zero("R1 in reset");
    clear_inputs();
    rst_n = 1'b1;
    @(posedge clk); #2 check_zero("R1 after reset");

    // R5: nothing enabled, data present
    port_fast = 4'b0101; phy_rxd = 16'hA5C3; phy_rx_dv = '1; phy_rx_er = '1;
    step("R5 idle");

    // R2: single fast port 2
    port_fast = 4'b1111; sep_rx_en100 = 4'b0100; phy_rxd = 16'h3B7E; phy_rx_dv = 4'b0100;
    step("R2 single fast");
    // R6: ports 1 and 3 both enabled on fast bus
    sep_rx_en100 = 4'b1010;
    step("R6 fast contention");
    // R3 and R6 slow: ports 0 and 2 slow both enabled
    port_fast = 4'b1010; sep_rx_en100 = '0; sep_rx_en10 = 4'b0101; phy_rxd = 16'h0001;
    step("R6 slow contention");
    // R4: wrong-speed enables only
    port_fast = 4'b0011; sep_rx_en10 = 4'b0011; sep_rx_en100 = 4'b1100;
    sep_tx_en10 = 4'b0011; sep_tx_en100 = 4'b1100; fast_txd = 4'hF; slow_txd = 1;
    step("R4 wrong speed");
    // R10: separate submode ignores common enables
    clear_inputs();
    port_fast = 4'b0110; cmn_rx_en = '1; cmn_tx_en = '1; phy_rxd = 16'hFFFF;
    phy_rx_dv = '1; fast_txd = 4'h9; slow_txd = 1; phy_crs = 4'b1001;
    step("R10 separate ignores common");
    // R9: smart submode ignores separate enables
    clear_inputs();
    smart_sel = 1; port_fast = 4'b0110; sep_rx_en10 = '1; sep_rx_en100 = '1;
    sep_tx_en10 = '1; sep_tx_en100 = '1; phy_rxd = 16'hFFFF; phy_crs = 4'b0011; phy_col = 4'b1100;
    step("R9 smart ignores separate");
    // R7: smart transmit to one fast and one slow port
    cmn_tx_en = 4'b0011; fast_txd = 4'hC; fast_tx_er = 1; slow_txd = 1; port_fast = 4'b0001;
    step("R7 smart tx");

    for (int k = 0; k < 400; k++) begin
      smart_sel    = 1'($urandom);
      port_fast    = 4'($urandom);
      phy_rxd      = 16'($urandom);
      phy_rx_dv    = 4'($urandom);
      phy_rx_er    = 4'($urandom);
      phy_crs      = 4'($urandom);
      phy_col      = 4'($urandom);
      sep_rx_en10  = 4'($urandom) & 4'($urandom);
      sep_rx_en100 = 4'($urandom) & 4'($urandom);
      sep_tx_en10  = 4'($urandom);
      sep_tx_en100 = 4'($urandom);
      cmn_rx_en    = 4'($urandom) & 4'($urandom);
      cmn_tx_en    = 4'($urandom);
      fast_txd     = 4'($urandom);
      fast_tx_er   = 1'($urandom);
      slow_txd     = 1'($urandom);
      step("random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule